// File: doc/BRIEF.md
# Conditional Move Condition Evaluator

This block decides whether a conditional register move takes effect and produces the value the destination register will hold afterwards. Each request carries a 4-bit condition code, the five arithmetic flags (overflow, carry, zero, sign, parity), an operand-size select, the current destination value and the source operand. The source operand is always supplied, whether or not the move happens. The block evaluates the condition, merges source and destination according to the operand size, and presents the result one cycle later together with a taken indication.

Requests enter on a valid/ready handshake and results leave on another. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. A result is consumed on a rising edge where `out_valid` and `out_ready` are both high. The block holds one result. While that result waits with `out_ready` low, `in_ready` stays low and the result stays frozen. When `out_ready` is high, a new request can be accepted in the same cycle the old result leaves, so the block keeps up with one request per cycle.

In the 32-bit size the write path zero-extends into the 64-bit destination. In the 16-bit size, only the low 16 bits are ever replaced.

Top module: `cmv_unit`

## Requirements
- R1: For condition codes 0 to 11, an odd code is the inverse of the even code just below it. Code 0 is taken when overflow is set and code 1 when it is clear. Codes 2 and 3 test carry in the same way, and codes 4 and 5 test zero.
- R2: Code 6 is taken when carry or zero (or both) is set. Code 7 is taken only when carry and zero are both clear.
- R3: Codes 8 and 9 are taken when sign is set and clear, respectively. Codes 10 and 11 are taken when parity is set and clear, respectively.
- R4: Code 12 is taken when sign differs from overflow. Code 13 is taken when sign equals overflow.
- R5: Code 14 is taken when zero is set or sign differs from overflow. Code 15 is taken when zero is clear and sign equals overflow.
- R6: With `in_wide` = 1 (32-bit size), bits 63:32 of the result are zero whether or not the condition holds. Bits 31:0 come from the source when taken and from the destination otherwise.
- R7: With `in_wide` = 0 (16-bit size) and the condition taken, bits 15:0 of the result come from the source and bits 63:16 keep the destination value.
- R8: With `in_wide` = 0 and the condition not taken, the result equals the destination value unchanged.
- R9: A request accepted on one rising edge produces `out_valid` = 1 with its `out_dst` and `out_taken` after that same edge, one cycle of latency. `out_taken` is 1 exactly when the condition held.
- R10: `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` = 1 and `out_ready` = 0, `out_dst` and `out_taken` stay stable and no request is accepted.
- R11: On a rising edge with `rst_n` low, the reset is synchronous and clears `out_valid`, `out_dst` and `out_taken` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted this cycle |
| in_cond | input | 4 | Condition code, 0 to 15 |
| flag_ovf | input | 1 | Overflow flag |
| flag_cry | input | 1 | Carry flag |
| flag_zro | input | 1 | Zero flag |
| flag_sgn | input | 1 | Sign flag |
| flag_par | input | 1 | Parity flag |
| in_wide | input | 1 | 1: 32-bit size (zero-extend), 0: 16-bit size |
| in_dst | input | 64 | Current destination value |
| in_src | input | 64 | Source operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts the result |
| out_dst | output | 64 | Next destination value |
| out_taken | output | 1 | Condition held |

## Verification
Every result is due exactly one rising edge after its request is accepted, and after that it stays on the outputs until a handshake with `out_ready` high consumes it. The reference model in the bench advances on each rising edge: it pushes an expected entry into a queue when a request is accepted and pops the head when a result is consumed. On the following falling edge the bench compares the ports with the queue head, so every check samples one edge after the event it expects. Back-pressure stretches are checked the same way: the queue head does not move, so any drift in the held outputs shows up as a mismatch. Reset is checked at the falling edge after a rising edge with `rst_n` low.

// File: rtl/cmv_pkg.sv
package cmv_pkg;

  // Condition codes are grouped in pairs; the upper three bits pick the pair,
  // the lowest bit inverts the test.
  typedef enum logic [2:0] {
    PAIR_OVF  = 3'd0,
    PAIR_CRY  = 3'd1,
    PAIR_ZRO  = 3'd2,
    PAIR_BE   = 3'd3,
    PAIR_SGN  = 3'd4,
    PAIR_PAR  = 3'd5,
    PAIR_LT   = 3'd6,
    PAIR_LE   = 3'd7
  } cmv_pair_e;

  typedef struct packed {
    logic ovf;
    logic cry;
    logic zro;
    logic sgn;
    logic par;
  } cmv_flags_t;

endpackage

// File: rtl/cmv_cond_eval.sv
module cmv_cond_eval
  import cmv_pkg::*;
(
  input  logic [3:0]  cc,
  input  cmv_flags_t  flags,
  output logic        taken
);

  cmv_pair_e pair;
  logic      base;
  logic      sgn_ne_ovf;

  assign pair       = cmv_pair_e'(cc[3:1]);
  assign sgn_ne_ovf = flags.sgn ^ flags.ovf;

  // Evaluate the even member of each pair; the odd member is its inverse.
  always_comb begin
    unique case (pair)
      PAIR_OVF: base = flags.ovf;
      PAIR_CRY: base = flags.cry;
      PAIR_ZRO: base = flags.zro;
      PAIR_BE:  base = flags.cry | flags.zro;
      PAIR_SGN: base = flags.sgn;
      PAIR_PAR: base = flags.par;
      PAIR_LT:  base = sgn_ne_ovf;
      PAIR_LE:  base = flags.zro | sgn_ne_ovf;
      default:  base = 1'b0;
    endcase
  end

  assign taken = base ^ cc[0];

endmodule

// File: rtl/cmv_merge.sv
module cmv_merge #(
  parameter int DATA_W   = 64,
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              wide,
  input  logic              taken,
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] nxt
);

  // Wide path: zero-extended, low part selected by the condition.
  logic [WIDE_W-1:0]   wide_low;
  // Narrow path: only the low part may change.
  logic [NARROW_W-1:0] narrow_low;

  assign wide_low   = taken ? src[WIDE_W-1:0]   : dst[WIDE_W-1:0];
  assign narrow_low = taken ? src[NARROW_W-1:0] : dst[NARROW_W-1:0];

  always_comb begin
    if (wide) begin
      nxt               = '0;
      nxt[WIDE_W-1:0]   = wide_low;
    end else begin
      nxt               = dst;
      nxt[NARROW_W-1:0] = narrow_low;
    end
  end

endmodule

// File: rtl/cmv_out_stage.sv
module cmv_out_stage #(
  parameter int PAY_W = 65
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [PAY_W-1:0] up_pay,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic [PAY_W-1:0] dn_pay
);

  logic             vld_q;
  logic [PAY_W-1:0] pay_q;

  // A slot is free when empty or when its content leaves this cycle.
  assign up_ready = ~vld_q | dn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      pay_q <= '0;
    end else if (up_ready) begin
      vld_q <= up_valid;
      if (up_valid) pay_q <= up_pay;
    end
  end

  assign dn_valid = vld_q;
  assign dn_pay   = pay_q;

endmodule

// File: rtl/cmv_unit.sv
module cmv_unit #(
  parameter int DATA_W   = 64,
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_cond,
  input  logic              flag_ovf,
  input  logic              flag_cry,
  input  logic              flag_zro,
  input  logic              flag_sgn,
  input  logic              flag_par,
  input  logic              in_wide,
  input  logic [DATA_W-1:0] in_dst,
  input  logic [DATA_W-1:0] in_src,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_dst,
  output logic              out_taken
);
  import cmv_pkg::*;

  localparam int PAY_W = DATA_W + 1;

  cmv_flags_t        flags;
  logic              taken;
  logic [DATA_W-1:0] merged;
  logic [PAY_W-1:0]  pay_out;

  assign flags = '{ovf: flag_ovf, cry: flag_cry, zro: flag_zro,
                   sgn: flag_sgn, par: flag_par};

  cmv_cond_eval u_eval (
    .cc    (in_cond),
    .flags (flags),
    .taken (taken)
  );

  cmv_merge #(
    .DATA_W   (DATA_W),
    .WIDE_W   (WIDE_W),
    .NARROW_W (NARROW_W)
  ) u_merge (
    .wide  (in_wide),
    .taken (taken),
    .dst   (in_dst),
    .src   (in_src),
    .nxt   (merged)
  );

  cmv_out_stage #(
    .PAY_W (PAY_W)
  ) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_pay   ({taken, merged}),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_pay   (pay_out)
  );

  assign out_taken = pay_out[PAY_W-1];
  assign out_dst   = pay_out[DATA_W-1:0];

endmodule

// File: rtl/cmv_unit_chk.sv
module cmv_unit_chk #(
  parameter int DATA_W   = 64,
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [3:0]        in_cond,
  input logic              flag_ovf,
  input logic              flag_cry,
  input logic              flag_zro,
  input logic              flag_sgn,
  input logic              flag_par,
  input logic              in_wide,
  input logic [DATA_W-1:0] in_dst,
  input logic [DATA_W-1:0] in_src,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_dst,
  input logic              out_taken
);

  logic acc;
  assign acc = in_valid & in_ready;

  // R1
  a_r1_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_cond == 4'd0 |=> out_taken == $past(flag_ovf));

  // R2
  a_r2_above: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_cond == 4'd7 |=> out_taken == $past(!flag_cry && !flag_zro));

  // R3
  a_r3_par_set: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_cond == 4'd10 |=> out_taken == $past(flag_par));

  // R4
  a_r4_less: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_cond == 4'd12 |=> out_taken == $past(flag_sgn != flag_ovf));

  // R5
  a_r5_greater: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_cond == 4'd15 |=> out_taken == $past(!flag_zro && flag_sgn == flag_ovf));

  // R6
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_wide |=> out_dst[DATA_W-1:WIDE_W] == '0);

  // R7
  a_r7_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_wide |=> out_dst[DATA_W-1:NARROW_W] == $past(in_dst[DATA_W-1:NARROW_W]));

  // R7 (source low part)
  a_r7_low_src: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_wide |=> !out_taken || out_dst[NARROW_W-1:0] == $past(in_src[NARROW_W-1:0]));

  // R8
  a_r8_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_wide |=> out_taken || out_dst == $past(in_dst));

  // R9
  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R10
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_dst) && $stable(out_taken));

  // R10 (no accept under stall)
  a_r10_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R11
  a_r11_reset: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !out_taken && out_dst == '0);

  // Operand inputs are read only in the checks above; keep every pin used.
  logic unused_ok;
  assign unused_ok = ^{in_src[DATA_W-1:NARROW_W], flag_par};

endmodule

bind cmv_unit cmv_unit_chk #(
  .DATA_W   (DATA_W),
  .WIDE_W   (WIDE_W),
  .NARROW_W (NARROW_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_cond   (in_cond),
  .flag_ovf  (flag_ovf),
  .flag_cry  (flag_cry),
  .flag_zro  (flag_zro),
  .flag_sgn  (flag_sgn),
  .flag_par  (flag_par),
  .in_wide   (in_wide),
  .in_dst    (in_dst),
  .in_src    (in_src),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_dst   (out_dst),
  .out_taken (out_taken)
);

// File: tb/tb_cmv_unit.sv
`timescale 1ns/1ps
module tb_cmv_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_cond = '0;
  logic        flag_ovf = 0, flag_cry = 0, flag_zro = 0, flag_sgn = 0, flag_par = 0;
  logic        in_wide = 1'b0;
  logic [63:0] in_dst = '0, in_src = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_dst;
  logic        out_taken;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  cmv_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cond(in_cond), .flag_ovf(flag_ovf), .flag_cry(flag_cry),
    .flag_zro(flag_zro), .flag_sgn(flag_sgn), .flag_par(flag_par),
    .in_wide(in_wide), .in_dst(in_dst), .in_src(in_src),
    .out_valid(out_valid), .out_ready(out_ready), .out_dst(out_dst),
    .out_taken(out_taken)
  );

  typedef struct {
    logic [63:0] data;
    logic        taken;
    int          creq;  // requirement tag number for the condition
    int          dreq;  // requirement tag number for the data merge
  } exp_t;

  exp_t exp_q[$];

  // Condition table: R1 R2 R3 R4 R5
  function automatic bit ref_cond(input logic [3:0] cc, input bit o, c, z, s, p);
    case (cc)
      4'd0:  return o;
      4'd1:  return !o;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return z;
      4'd5:  return !z;
      4'd6:  return c || z;
      4'd7:  return !c && !z;
      4'd8:  return s;
      4'd9:  return !s;
      4'd10: return p;
      4'd11: return !p;
      4'd12: return s != o;
      4'd13: return s == o;
      4'd14: return z || (s != o);
      default: return !z && (s == o);
    endcase
  endfunction

  function automatic int cond_req(input logic [3:0] cc);
    if (cc <= 4'd5 || cc == 4'd10 || cc == 4'd11) return (cc >= 4'd10) ? 3 : 1;
    if (cc <= 4'd7)  return 2;
    if (cc <= 4'd9)  return 3;
    if (cc <= 4'd13) return 4;
    return 5;
  endfunction

  function automatic exp_t make_exp();
    exp_t e;
    e.taken = ref_cond(in_cond, flag_ovf, flag_cry, flag_zro, flag_sgn, flag_par);
    e.creq  = cond_req(in_cond);
    if (in_wide) begin  // R6
      e.data = {32'h0, e.taken ? in_src[31:0] : in_dst[31:0]};
      e.dreq = 6;
    end else if (e.taken) begin  // R7
      e.data = {in_dst[63:16], in_src[15:0]};
      e.dreq = 7;
    end else begin  // R8
      e.data = in_dst;
      e.dreq = 8;
    end
    return e;
  endfunction

  // Reference model, advanced on every rising edge.
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      exp_q.delete();
    end else begin
      bit rdy;
      exp_t e;
      rdy = (exp_q.size() == 0) || out_ready;
      e = make_exp();
      if (exp_q.size() != 0 && out_ready) void'(exp_q.pop_front());
      if (in_valid && rdy) exp_q.push_back(e);
    end
  end

  task automatic chk(input bit ok, input int req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d actual=%h expected=%h at cycle %0d", req, act, expv, cycles);
    end
  endtask

  // Advance one clock and compare the ports with the model at the falling edge.
  task automatic tick();
    @(negedge clk);
    if (!rst_n) begin
      // R11: reset clears the outputs
      chk(out_valid == 1'b0, 11, {63'h0, out_valid}, 64'h0);
      chk(out_taken == 1'b0, 11, {63'h0, out_taken}, 64'h0);
      chk(out_dst == 64'h0, 11, out_dst, 64'h0);
    end else begin
      bit ev;
      ev = exp_q.size() != 0;
      // R9: valid one edge after acceptance
      chk(out_valid == ev, 9, {63'h0, out_valid}, {63'h0, ev});
      // R10: ready rule
      chk(in_ready == (!ev || out_ready), 10, {63'h0, in_ready}, {63'h0, (!ev || out_ready)});
      if (ev && out_valid) begin
        chk(out_taken == exp_q[0].taken, exp_q[0].creq, {63'h0, out_taken}, {63'h0, exp_q[0].taken});
        chk(out_dst == exp_q[0].data, exp_q[0].dreq, out_dst, exp_q[0].data);
      end
    end
  endtask

  task automatic rand_req(input logic [3:0] cc, input logic [4:0] f);
    in_cond  = cc;
    {flag_ovf, flag_cry, flag_zro, flag_sgn, flag_par} = f;
    in_wide  = 1'($urandom);
    in_dst   = {$urandom, $urandom};
    in_src   = {$urandom, $urandom};
  endtask

  // Watchdog: counts as a failed check and still prints the summary.
  initial begin
    wait (cycles >= 150000);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    @(posedge clk);
    tick();  // R11 reset state
    tick();
    rst_n = 1'b1;

    // Exhaustive sweep of codes and flag patterns, R1 to R8, full throughput.
    for (int cc = 0; cc < 16; cc++) begin
      for (int f = 0; f < 32; f++) begin
        in_valid  = 1'b1;
        out_ready = 1'b1;
        rand_req(4'(cc), 5'(f));
        tick();
      end
    end

    // Narrow size, directed taken and not taken: R7 R8
    in_valid = 1'b1; out_ready = 1'b1;
    rand_req(4'd4, 5'b00100); in_wide = 1'b0; tick();
    rand_req(4'd4, 5'b00000); in_wide = 1'b0; tick();
    // Wide size, not taken still clears upper half: R6
    rand_req(4'd2, 5'b00000); in_wide = 1'b1; in_dst = 64'hFFFF_FFFF_FFFF_FFFF; tick();

    // Back-pressure: R10
    rand_req(4'd13, 5'b00000);
    out_ready = 1'b0;
    tick();
    in_valid = 1'b1;
    rand_req(4'd12, 5'b10000);
    repeat (5) tick();
    out_ready = 1'b1;
    tick();
    in_valid = 1'b0;
    tick();

    // Random traffic with random back-pressure.
    for (int n = 0; n < 3000; n++) begin
      in_valid  = ($urandom % 4) != 0;
      out_ready = ($urandom % 4) != 0;
      rand_req(4'($urandom), 5'($urandom));
      tick();
    end

    // Reset in the middle of traffic: R11
    in_valid = 1'b1; out_ready = 1'b0;
    rand_req(4'd6, 5'b01000);
    tick();
    rst_n = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
    out_ready = 1'b1;
    rand_req(4'd14, 5'b00100);
    tick();
    in_valid = 1'b0;
    tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule